// File: doc/BRIEF.md
# Serviced Watchdog Timer with Early-Warning Interrupt

This block guards a system against software that stops making progress. A down-counter runs from an external half-second tick. Software must keep refilling it by writing two fixed words to a service register in order. If the counter runs out, the block records a timeout as the reset cause and raises a one-cycle reset request.

Software can also ask for a reset directly through the control register. An optional early-warning stage raises an interrupt a programmable number of ticks before the counter expires, so software can log state or recover first.

All registers are 16 bits wide. The bus addresses whole 16-bit words by index, so every access is aligned. Reads are combinational on the word index. Several control and interrupt fields are write-once and stay fixed until reset.

Top module: `svc_watchdog`

## Requirements
- R1: After reset the registers read as follows: control (index 0) 0x0030, service (index 1) 0x0000, cause (index 2) 0x0000, interrupt control (index 3) 0x0004, misc (index 4) 0x0001. `irq` and `rst_req` are low.
- R2: The timeout field is control bits [15:8]. A control write with enable (bit 2) set and timeout field N > 0 starts the count. The N+1-th following tick pulses `rst_req` for one cycle, and the cause register then reads 0x0002.
- R3: A write of 0xAAAA to the service register refills the count to N+1, but only when the service register held 0x5555 just before. Any other pair does not refill. The service register always reads back the last word written to it.
- R4: Once the enable bit (control bit 2) is 1, later control writes cannot clear it.
- R5: Once the timeout-lock bit (control bit 3) is 1, it stays 1 and the timeout field [15:8] ignores later writes.
- R6: A control write with bit 4 at 0 sets the cause register to 0x0001. Control bit 4 always reads back as 1.
- R7: A control write whose bits 5 and 4 are both 0 pulses `rst_req` in the cycle after the write. So does a write that leaves enable set with a zero timeout field. A write with bits 5 and 4 at 1 and enable clear does not pulse it.
- R8: If interrupt control bit 15 (enable) is set and its threshold field [7:0] is T, with T < N+1 when the count starts, then `irq` and interrupt control bit 14 rise at tick N+1-T.
- R9: Writing 1 to interrupt control bit 14 clears it and drops `irq`. Writing 0 to it has no effect.
- R10: The early warning is armed only if the interrupt is enabled and the count exceeds T. When T >= N+1, or when the interrupt is disabled, `irq` stays low through expiry.
- R11: The first interrupt-control write fixes bit 15 and field [7:0]. Later writes change only bit 14.
- R12: The cause register ignores writes. In the misc register only bit 0 is writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per half-second count period |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write access |
| bus_addr | input | 3 | 16-bit word index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Early-warning interrupt, level |

## Verification
The hardest case to reach is an early-warning interrupt that lands at exactly the right tick. It needs an unlocked interrupt setup first, then a start with a timeout wider than the threshold, and the write-once locks allow only one such setup per reset. The stimulus therefore resets the block before each trial. Each trial draws a timeout, a threshold spanning both sides of the count and an enable from a seeded generator. It then counts ticks to the interrupt and to expiry against values computed by bench functions. Directed sequences cover the refill pair, broken pairs, the locks and the immediate reset triggers.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DW      = 16;
  localparam int TMO_W   = 8;
  localparam int TMO_LSB = 8;
  localparam int CNT_W   = TMO_W + 1;
  localparam int THR_W   = 8;
  localparam int AW      = 3;

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_SVC  = 3'd1;
  localparam logic [AW-1:0] A_STAT = 3'd2;
  localparam logic [AW-1:0] A_ICTL = 3'd3;
  localparam logic [AW-1:0] A_MISC = 3'd4;

  localparam int B_EN   = 2;
  localparam int B_TLK  = 3;
  localparam int B_SRS  = 4;
  localparam int B_WDA  = 5;
  localparam int B_FLAG = 14;
  localparam int B_PEN  = 15;

  localparam logic [DW-1:0] SEQ_A   = 16'h5555;
  localparam logic [DW-1:0] SEQ_B   = 16'hAAAA;
  localparam logic [DW-1:0] CTL_RST = 16'h0030;
  localparam logic [DW-1:0] STAT_SW = 16'h0001;
  localparam logic [DW-1:0] STAT_TO = 16'h0002;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             reload,
  input  logic             en,
  input  logic [TMO_W-1:0] tmo,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d,
  output logic             run_d,
  output logic             dec,
  output logic             expire_hit
);
  logic             run_q;
  logic             live;
  logic [CNT_W-1:0] full;

  always_comb begin
    live       = en && (tmo != '0);
    full       = {1'b0, tmo} + CNT_W'(1);
    dec        = tick && run_q && !start && !reload;
    expire_hit = dec && (cnt_q == CNT_W'(1));
    cnt_d      = cnt_q;
    run_d      = run_q;
    if (start) begin
      run_d = live;
      cnt_d = live ? full : '0;
    end else if (reload) begin
      if (live) cnt_d = full;
    end else if (dec) begin
      cnt_d = cnt_q - CNT_W'(1);
      run_d = (cnt_q != CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  p_run_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != '0));
  p_dec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dec |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/wdog_pto.sv
module wdog_pto
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_evt,
  input  logic             dec,
  input  logic             pen,
  input  logic [THR_W-1:0] thr,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic             run_d,
  output logic             fire_hit
);
  logic             armed_q, armed_d, armed_eff;
  logic [CNT_W-1:0] thr_x;

  always_comb begin
    thr_x     = {1'b0, thr};
    armed_eff = arm_evt ? (pen && (cnt_q > thr_x)) : armed_q;
    fire_hit  = dec && armed_eff && ((cnt_q - CNT_W'(1)) == thr_x);
    if (fire_hit)     armed_d = 1'b0;
    else if (arm_evt) armed_d = run_d && pen && (cnt_d > thr_x);
    else              armed_d = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  p_fire_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire_hit |=> (cnt_q == {1'b0, $past(thr)}));
  p_fire_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire_hit |-> pen);
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter bit               PTO_EN  = 1'b1,
  parameter logic [THR_W-1:0] THR_DEF = 8'h04
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             expire_hit,
  input  logic             fire_hit,
  output logic [DW-1:0]    bus_rdata,
  output logic             ctl_en,
  output logic [TMO_W-1:0] ctl_tmo,
  output logic             pen,
  output logic [THR_W-1:0] thr,
  output logic             start_q,
  output logic             reload_q,
  output logic             arm_q,
  output logic             rst_req,
  output logic             irq
);
  logic [DW-1:0]    ctl_q, ctl_d, ctl_eff, svc_q, svc_d, stat_q, stat_d;
  logic [THR_W-1:0] thr_q, thr_d;
  logic             pen_q, pen_d, flag_q, flag_d, ilk_q, ilk_d, pd_q, pd_d;
  logic             rst_q, rst_d, start_d, reload_d, arm_d;
  logic             ctl_we, svc_we, ictl_we, misc_we, sw_hit, imm_hit;

  always_comb begin
    ctl_we  = bus_sel && bus_wr && (bus_addr == A_CTRL);
    svc_we  = bus_sel && bus_wr && (bus_addr == A_SVC);
    ictl_we = bus_sel && bus_wr && (bus_addr == A_ICTL) && PTO_EN;
    misc_we = bus_sel && bus_wr && (bus_addr == A_MISC);

    ctl_eff = bus_wdata;
    if (ctl_q[B_TLK]) begin
      ctl_eff[TMO_LSB +: TMO_W] = ctl_q[TMO_LSB +: TMO_W];
      ctl_eff[B_TLK]            = 1'b1;
    end
    if (ctl_q[B_EN]) ctl_eff[B_EN] = 1'b1;
    ctl_eff[B_SRS] = 1'b1;
    ctl_d   = ctl_we ? ctl_eff : ctl_q;

    sw_hit  = ctl_we && !bus_wdata[B_SRS];
    imm_hit = ctl_we && ((!bus_wdata[B_WDA] && !bus_wdata[B_SRS]) ||
                         (ctl_eff[B_EN] && (ctl_eff[TMO_LSB +: TMO_W] == '0)));
    if (sw_hit)          stat_d = STAT_SW;
    else if (expire_hit) stat_d = STAT_TO;
    else                 stat_d = stat_q;
    rst_d    = imm_hit || (expire_hit && ctl_q[B_EN]);

    svc_d    = svc_we ? bus_wdata : svc_q;
    reload_d = svc_we && (svc_q == SEQ_A) && (bus_wdata == SEQ_B);
    start_d  = ctl_we;
    arm_d    = ictl_we;

    pen_d  = pen_q;
    thr_d  = thr_q;
    flag_d = flag_q;
    ilk_d  = ilk_q;
    if (ictl_we) begin
      if (!ilk_q) begin
        pen_d = bus_wdata[B_PEN];
        thr_d = bus_wdata[THR_W-1:0];
      end
      if (bus_wdata[B_FLAG]) flag_d = 1'b0;
      ilk_d = 1'b1;
    end
    if (fire_hit) flag_d = 1'b1;

    pd_d = misc_we ? bus_wdata[0] : pd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= CTL_RST;
      svc_q    <= '0;
      stat_q   <= '0;
      thr_q    <= THR_DEF;
      pen_q    <= 1'b0;
      flag_q   <= 1'b0;
      ilk_q    <= 1'b0;
      pd_q     <= 1'b1;
      rst_q    <= 1'b0;
      start_q  <= 1'b0;
      reload_q <= 1'b0;
      arm_q    <= 1'b0;
    end else begin
      ctl_q    <= ctl_d;
      svc_q    <= svc_d;
      stat_q   <= stat_d;
      thr_q    <= thr_d;
      pen_q    <= pen_d;
      flag_q   <= flag_d;
      ilk_q    <= ilk_d;
      pd_q     <= pd_d;
      rst_q    <= rst_d;
      start_q  <= start_d;
      reload_q <= reload_d;
      arm_q    <= arm_d;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctl_q;
      A_SVC:   bus_rdata = svc_q;
      A_STAT:  bus_rdata = stat_q;
      A_ICTL:  bus_rdata = {pen_q, flag_q, {(DW-THR_W-2){1'b0}}, thr_q};
      A_MISC:  bus_rdata = {{(DW-1){1'b0}}, pd_q};
      default: bus_rdata = '0;
    endcase
  end

  assign ctl_en  = ctl_q[B_EN];
  assign ctl_tmo = ctl_q[TMO_LSB +: TMO_W];
  assign pen     = pen_q;
  assign thr     = thr_q;
  assign rst_req = rst_q;
  assign irq     = flag_q;

  p_en_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[B_EN] |=> ctl_q[B_EN]);
  p_tmo_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[B_TLK] |=> (ctl_q[B_TLK] && $stable(ctl_q[TMO_LSB +: TMO_W])));
  p_srs_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[B_SRS]);
  p_ictl_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ilk_q |=> $stable({pen_q, thr_q}));
  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(fire_hit));
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
  import wdog_pkg::*;
#(
  parameter bit               PTO_EN  = 1'b1,
  parameter logic [THR_W-1:0] THR_DEF = 8'h04
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          rst_req,
  output logic          irq
);
  logic             rst_ni;
  logic             ctl_en, pen, start_q, reload_q, arm_q;
  logic [TMO_W-1:0] ctl_tmo;
  logic [THR_W-1:0] thr;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_d, dec, expire_hit, fire_hit;

  wdog_rst_sync u_sync (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_ni));

  wdog_regs #(.PTO_EN(PTO_EN), .THR_DEF(THR_DEF)) u_regs (
    .clk(clk), .rst_n(rst_ni), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .expire_hit(expire_hit),
    .fire_hit(fire_hit), .bus_rdata(bus_rdata), .ctl_en(ctl_en),
    .ctl_tmo(ctl_tmo), .pen(pen), .thr(thr), .start_q(start_q),
    .reload_q(reload_q), .arm_q(arm_q), .rst_req(rst_req), .irq(irq));

  wdog_count u_count (
    .clk(clk), .rst_n(rst_ni), .tick(tick), .start(start_q),
    .reload(reload_q), .en(ctl_en), .tmo(ctl_tmo), .cnt_q(cnt_q),
    .cnt_d(cnt_d), .run_d(run_d), .dec(dec), .expire_hit(expire_hit));

  generate
    if (PTO_EN) begin : g_pto
      wdog_pto u_pto (
        .clk(clk), .rst_n(rst_ni), .arm_evt(start_q | arm_q), .dec(dec),
        .pen(pen), .thr(thr), .cnt_q(cnt_q), .cnt_d(cnt_d),
        .run_d(run_d), .fire_hit(fire_hit));
    end else begin : g_no_pto
      assign fire_hit = 1'b0;
    end
  endgenerate
endmodule

// File: tb/svc_watchdog_tb.sv
module svc_watchdog_tb;
  localparam time CYC = 20ns;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'h0, rdata;
  logic        rst_req, irq, wr_rst;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  svc_watchdog u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .rst_req(rst_req), .irq(irq));

  always #(CYC/2) clk = ~clk;

  function automatic int exp_irq_tick(int n, int t, bit en);
    if (en && (n + 1 > t)) return n + 1 - t;
    return 0;
  endfunction

  function automatic logic [15:0] exp_misc(logic [15:0] w);
    return {15'h0, w[0]};
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0; wr_rst = rst_req;
    @(negedge clk);
  endtask

  task automatic rreg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic tick_once(output logic r, output logic i);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; r = rst_req; i = irq;
  endtask

  task automatic run_ticks(input int lim, output int rk, output int ik);
    logic r, i;
    rk = 0; ik = 0;
    for (int k = 1; k <= lim; k++) begin
      tick_once(r, i);
      if (r && rk == 0) rk = k;
      if (i && ik == 0) ik = k;
    end
  endtask

  initial begin
    #(CYC * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int rk, ik;
    void'($urandom(32'd4242));
    do_reset();

    // R1 reset values
    rreg(3'd0, v); chk("R1 ctrl", v, 16'h0030);
    rreg(3'd1, v); chk("R1 svc", v, 16'h0000);
    rreg(3'd2, v); chk("R1 cause", v, 16'h0000);
    rreg(3'd3, v); chk("R1 ictl", v, 16'h0004);
    rreg(3'd4, v); chk("R1 misc", v, 16'h0001);
    chk("R1 pins", {14'h0, irq, rst_req}, 16'h0);

    // R12 cause read-only, misc bit0 only
    wreg(3'd2, 16'hFFFF); rreg(3'd2, v); chk("R12 cause ro", v, 16'h0000);
    for (int j = 0; j < 6; j++) begin
      logic [15:0] w = 16'($urandom);
      wreg(3'd4, w); rreg(3'd4, v); chk("R12 misc", v, exp_misc(w));
    end

    // R7 no pulse on plain write, pulse on both bits cleared
    wreg(3'd0, 16'h0A30); chk("R7 quiet", {15'h0, wr_rst}, 16'h0);
    wreg(3'd0, 16'h0A00); chk("R7 both clear", {15'h0, wr_rst}, 16'h1);
    rreg(3'd2, v); chk("R6 sw cause", v, 16'h0001);
    rreg(3'd0, v); chk("R6 srs reads 1", v, 16'h0A10);
    do_reset();
    wreg(3'd0, 16'h0034); chk("R7 en zero tmo", {15'h0, wr_rst}, 16'h1);

    // R4 enable sticky, R6 sw cause without reset pulse
    do_reset();
    wreg(3'd0, 16'h0A34);
    wreg(3'd0, 16'h0A30); rreg(3'd0, v); chk("R4 en sticky", v, 16'h0A34);
    wreg(3'd0, 16'h0A24); chk("R6 no pulse", {15'h0, wr_rst}, 16'h0);
    rreg(3'd2, v); chk("R6 cause", v, 16'h0001);

    // R5 timeout lock
    do_reset();
    wreg(3'd0, 16'h0A38);
    wreg(3'd0, 16'h0530); rreg(3'd0, v); chk("R5 lock", v, 16'h0A38);

    // R3 valid refill
    do_reset();
    wreg(3'd0, 16'h0534);
    run_ticks(3, rk, ik); chk("R2 early", 16'(rk), 16'd0);
    wreg(3'd1, 16'h5555); wreg(3'd1, 16'hAAAA);
    run_ticks(8, rk, ik); chk("R3 refill", 16'(rk), 16'd6);
    rreg(3'd2, v); chk("R2 cause", v, 16'h0002);

    // R3 broken pair
    do_reset();
    wreg(3'd0, 16'h0534);
    run_ticks(3, rk, ik);
    wreg(3'd1, 16'h5555); wreg(3'd1, 16'h1234); wreg(3'd1, 16'hAAAA);
    rreg(3'd1, v); chk("R3 readback", v, 16'hAAAA);
    run_ticks(6, rk, ik); chk("R3 no refill", 16'(rk), 16'd3);

    // R8 R9 R11 flag handling
    do_reset();
    wreg(3'd3, 16'h8003);
    wreg(3'd0, 16'h0534);
    run_ticks(3, rk, ik); chk("R8 fire tick", 16'(ik), 16'd3);
    rreg(3'd3, v); chk("R8 flag", v, 16'hC003);
    wreg(3'd3, 16'h0005); rreg(3'd3, v); chk("R11 R9 no clear", v, 16'hC003);
    chk("R9 irq held", {15'h0, irq}, 16'h1);
    wreg(3'd3, 16'h4000); rreg(3'd3, v); chk("R9 cleared", v, 16'h8003);
    chk("R9 irq low", {15'h0, irq}, 16'h0);
    run_ticks(5, rk, ik);
    chk("R10 no refire", 16'(ik), 16'd0);
    chk("R2 expiry", 16'(rk), 16'd3);

    // R10 threshold at count
    do_reset();
    wreg(3'd3, 16'h8006);
    wreg(3'd0, 16'h0534);
    run_ticks(8, rk, ik); chk("R10 thr=N+1", 16'(ik), 16'd0);

    // R2 R8 R10 random trials
    for (int j = 0; j < 10; j++) begin
      int n   = int'($urandom_range(1, 20));
      int t   = int'($urandom_range(0, n + 3));
      bit pe  = bit'($urandom_range(0, 1));
      do_reset();
      wreg(3'd3, {pe, 7'h0, 8'(t)});
      wreg(3'd0, {8'(n), 8'h34});
      run_ticks(n + 3, rk, ik);
      chk("R2 rand expiry", 16'(rk), 16'(n + 1));
      chk("R8 R10 rand irq", 16'(ik), 16'(exp_irq_tick(n, t, pe)));
      rreg(3'd2, v); chk("R2 rand cause", v, 16'h0002);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule